// File: doc/BRIEF.md
# Dual-Modulus Loop Divider

This block divides a local-oscillator pulse stream down to the comparison rate of a frequency-synthesizer loop. The oscillator arrives as a one-cycle enable pulse in the system clock domain, at most one pulse per clock. A 13-bit code N and a band select set the ratio. In the high band the pulses go through a 64/65 dual-modulus prescaler that is steered by a swallow counter, so the overall ratio moves in steps of one input pulse. In the low band a fixed divide-by-8 stage feeds the same main counter, which then divides by N+1.

Each completed division produces one single-cycle output pulse, which goes to a phase comparator. The code and the band select are sampled only at the end of a division, so a controller can rewrite them at any time without corrupting the period in progress.

Top module: `dmd_loop_divider`

## Requirements
- R1: After reset the output is low and the active setting is low band with code 0, so the first division after reset spans 8 input pulses.
- R2: With the low band active (band select 0), one division spans 8*(N+1) input pulses.
- R3: With the high band active (band select 1), let T=N+1, A=T mod 64 and P=T div 64. When 1<=P and A<=P, one division spans 64*P+A = N+1 input pulses.
- R4: In the high band, codes outside the swallow range are clamped: P is raised to 1 if it is 0, A is lowered to P if it exceeds P, and the division spans 64*P+A input pulses (code 0 gives 65, code 8191 gives 8192).
- R5: In a high-band division the prescaler counts 65 input pulses in each of the first A prescaler periods and 64 in each of the rest. In the low band it counts 8, and no swallow is pending.
- R6: The code and band select are sampled only in the cycle that ends a division. Changes made during a division do not alter its length.
- R7: The output is a one-cycle pulse. It is high in the cycle after the clock edge that samples the input pulse completing a division.
- R8: Cycles without an input pulse advance no counter, and whatever the spacing of the input pulses, only their number decides when a division ends.
- R9: The active-low asynchronous reset clears all counters and the output at any time, and the division count restarts per R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lo_pulse_i | input | 1 | One-cycle pulse per oscillator period |
| fm_sel_i | input | 1 | Band select: 1 high band (64/65 path), 0 low band (divide-by-8 path) |
| code_i | input | 13 | Divide code N |
| div_pulse_o | output | 1 | One-cycle pulse at the end of each division |

## Verification
A wrong prescaler or swallow state changes the spacing of the output pulses. The error is seen at the next output pulse, which arrives early or late by one or more input pulses, so it appears within one division period. A setting latched at the wrong time shows up as a wrong length for the division that follows the write. A counter that advances on an idle cycle shows up as a short period under sparse input. The bench compares the output against a pulse-counting model on every clock, so any of these faults is flagged in the cycle where the pulse was due or arrived.

// File: rtl/dmd_pkg.sv
package dmd_pkg;
  typedef enum logic {
    BAND_AM = 1'b0,
    BAND_FM = 1'b1
  } band_e;
endpackage

// File: rtl/dmd_plan.sv
// Maps a code and band to the main-counter terminal and swallow load.
module dmd_plan #(
  parameter int CODE_W = 13,
  parameter int SWAL_W = 6
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic              fm_i,
  output logic [CODE_W-1:0] term_o,
  output logic [SWAL_W-1:0] swal_o
);
  localparam int TOT_W  = CODE_W + 1;
  localparam int MAIN_W = TOT_W - SWAL_W;

  logic [TOT_W-1:0]  tot;
  logic [SWAL_W-1:0] a_raw, a_eff;
  logic [MAIN_W-1:0] p_raw, p_eff;

  always_comb begin
    tot   = {1'b0, code_i} + TOT_W'(1);
    a_raw = tot[SWAL_W-1:0];
    p_raw = tot[TOT_W-1:SWAL_W];
    p_eff = (p_raw == '0) ? MAIN_W'(1) : p_raw;
    // swallow count cannot exceed the main count
    if (MAIN_W'(a_raw) > p_eff) a_eff = SWAL_W'(p_eff);
    else                        a_eff = a_raw;
    if (fm_i) begin
      term_o = CODE_W'(p_eff - MAIN_W'(1));
      swal_o = a_eff;
    end else begin
      term_o = code_i;
      swal_o = '0;
    end
  end
endmodule

// File: rtl/dmd_prescaler.sv
// 64/65 or fixed-ratio prescaler on the input enable stream.
module dmd_prescaler
  import dmd_pkg::*;
#(
  parameter int SWAL_W = 6,
  parameter int AM_DIV = 8,
  localparam int FM_BASE = 2 ** SWAL_W,
  localparam int CNT_W   = $clog2(FM_BASE + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lo_i,
  input  band_e            band_i,
  input  logic             extra_i,
  output logic             tc_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, lim;

  always_comb begin
    if (band_i == BAND_FM) lim = extra_i ? CNT_W'(FM_BASE) : CNT_W'(FM_BASE - 1);
    else                   lim = CNT_W'(AM_DIV - 1);
  end

  assign tc_o  = lo_i && (cnt_q == lim);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (lo_i) cnt_q <= tc_o ? '0 : cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/dmd_counter.sv
// Main and swallow counters, advanced by prescaler terminal counts.
module dmd_counter #(
  parameter int CODE_W = 13,
  parameter int SWAL_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pre_tc_i,
  input  logic [CODE_W-1:0] term_i,
  input  logic [SWAL_W-1:0] swal_load_i,
  output logic              main_tc_o,
  output logic              extra_o
);
  logic [CODE_W-1:0] main_q;
  logic [SWAL_W-1:0] swal_q;

  assign main_tc_o = pre_tc_i && (main_q == term_i);
  assign extra_o   = (swal_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      main_q <= '0;
      swal_q <= '0;
    end else if (main_tc_o) begin
      main_q <= '0;
      swal_q <= swal_load_i;
    end else if (pre_tc_i) begin
      main_q <= main_q + CODE_W'(1);
      if (extra_o) swal_q <= swal_q - SWAL_W'(1);
    end
  end
endmodule

// File: rtl/dmd_loop_divider.sv
module dmd_loop_divider
  import dmd_pkg::*;
#(
  parameter int CODE_W = 13,
  parameter int SWAL_W = 6,
  parameter int AM_DIV = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lo_pulse_i,
  input  logic              fm_sel_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              div_pulse_o
);
  localparam int PRE_W = $clog2(2 ** SWAL_W + 1);

  band_e             band_q;
  logic [CODE_W-1:0] term_q, term_nxt;
  logic [SWAL_W-1:0] swal_nxt;
  logic [PRE_W-1:0]  pre_cnt;
  logic              pre_tc, main_tc, extra;

  dmd_plan #(.CODE_W(CODE_W), .SWAL_W(SWAL_W)) u_plan (
    .code_i (code_i),
    .fm_i   (fm_sel_i),
    .term_o (term_nxt),
    .swal_o (swal_nxt)
  );

  dmd_prescaler #(.SWAL_W(SWAL_W), .AM_DIV(AM_DIV)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lo_i    (lo_pulse_i),
    .band_i  (band_q),
    .extra_i (extra),
    .tc_o    (pre_tc),
    .cnt_o   (pre_cnt)
  );

  dmd_counter #(.CODE_W(CODE_W), .SWAL_W(SWAL_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pre_tc_i    (pre_tc),
    .term_i      (term_q),
    .swal_load_i (swal_nxt),
    .main_tc_o   (main_tc),
    .extra_o     (extra)
  );

  // setting is taken only when a division completes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      band_q      <= BAND_AM;
      term_q      <= '0;
      div_pulse_o <= 1'b0;
    end else begin
      div_pulse_o <= main_tc;
      if (main_tc) begin
        band_q <= fm_sel_i ? BAND_FM : BAND_AM;
        term_q <= term_nxt;
      end
    end
  end
endmodule

// File: rtl/dmd_loop_divider_chk.sv
module dmd_loop_divider_chk
  import dmd_pkg::*;
#(
  parameter int CODE_W = 13,
  parameter int SWAL_W = 6,
  parameter int AM_DIV = 8,
  localparam int PRE_W = $clog2(2 ** SWAL_W + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lo_pulse_i,
  input logic              div_pulse_o,
  input band_e             band_q,
  input logic [CODE_W-1:0] term_q,
  input logic [PRE_W-1:0]  pre_cnt,
  input logic              extra
);
  a_r7_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_pulse_o |=> !div_pulse_o);

  a_r7_follows_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_pulse_o |-> $past(lo_pulse_i));

  a_r6_setting_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({band_q, term_q}) |-> div_pulse_o);

  a_r5_am_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (band_q == BAND_AM) |-> (pre_cnt < PRE_W'(AM_DIV)));

  a_r5_fm_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_cnt <= PRE_W'(2 ** SWAL_W));

  a_r5_no_swallow_am: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (band_q == BAND_AM) |-> !extra);

  a_r8_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lo_pulse_i |=> ($stable(pre_cnt) && !div_pulse_o));
endmodule

bind dmd_loop_divider dmd_loop_divider_chk #(
  .CODE_W(CODE_W), .SWAL_W(SWAL_W), .AM_DIV(AM_DIV)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lo_pulse_i  (lo_pulse_i),
  .div_pulse_o (div_pulse_o),
  .band_q      (band_q),
  .term_q      (term_q),
  .pre_cnt     (pre_cnt),
  .extra       (extra)
);

// File: tb/dmd_loop_divider_bench.sv
module dmd_loop_divider_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lo_pulse_i = 1'b0;
  logic        fm_sel_i = 1'b0;
  logic [12:0] code_i = '0;
  logic        div_pulse_o;

  int    vectors = 0;
  int    fails = 0;
  int    pulses = 0;
  int    cnt = 0;
  int    ratio = 8;
  bit    exp_pulse = 1'b0;
  bit    done = 1'b0;
  string cur_req = "R1";

  always #10 clk_i = ~clk_i;

  dmd_loop_divider u_dmd_loop_divider (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lo_pulse_i  (lo_pulse_i),
    .fm_sel_i    (fm_sel_i),
    .code_i      (code_i),
    .div_pulse_o (div_pulse_o)
  );

  function automatic int exp_ratio(int code, bit fm);
    int t = code + 1;
    int p = t / 64;
    int a = t % 64;
    if (!fm) return 8 * t;
    if (p < 1) p = 1;
    if (a > p) a = p;
    return 64 * p + a;
  endfunction

  // reference: count input pulses, latch next ratio at each boundary
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt = 0; ratio = 8; exp_pulse = 1'b0;
    end else begin
      exp_pulse = 1'b0;
      if (lo_pulse_i) begin
        cnt++;
        if (cnt == ratio) begin
          exp_pulse = 1'b1;
          cnt = 0;
          ratio = exp_ratio(int'(code_i), fm_sel_i);
          pulses++;
        end
      end
    end
  end

  // R7 timing is checked on every cycle by this compare
  always @(negedge clk_i) begin
    if (!done) begin
      vectors++;
      if (div_pulse_o !== exp_pulse) begin
        fails++;
        $display("FAIL %s t=%0t div_pulse_o=%b expected=%b", cur_req, $time, div_pulse_o, exp_pulse);
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  task automatic run_periods(int n, int dens);
    int target = pulses + n;
    while (pulses < target) begin
      @(negedge clk_i);
      lo_pulse_i <= (int'($urandom % 100) < dens);
    end
    @(negedge clk_i);
    lo_pulse_i <= 1'b0;
  endtask

  task automatic run_cycles(int n, int dens);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      lo_pulse_i <= (int'($urandom % 100) < dens);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    // R1: reset state, first division of 8
    cur_req = "R1";
    repeat (3) @(negedge clk_i);
    rst_ni <= 1'b1;
    run_periods(2, 100);

    // R2: low band, dense then code change
    cur_req = "R2";
    code_i <= 13'd5;
    run_periods(3, 100);

    // R8: sparse input keeps the same count
    cur_req = "R8";
    run_periods(3, 35);

    // R4: code 0 in the high band clamps to 65
    cur_req = "R4";
    fm_sel_i <= 1'b1;
    code_i   <= 13'd0;
    run_periods(3, 100);

    // R3 R5: valid swallow code, ratio N+1 = 4100
    cur_req = "R3 R5";
    code_i <= 13'd4099;
    run_periods(2, 100);

    // R4: A > P clamp (T=1001 gives 975), irregular input
    cur_req = "R4";
    code_i <= 13'd1000;
    run_periods(3, 70);

    // R3: largest code gives 8192
    cur_req = "R3";
    code_i <= 13'd8191;
    run_periods(2, 100);

    // R6: rewrite the setting mid-division
    cur_req = "R6";
    code_i <= 13'd200;
    run_periods(2, 100);
    run_cycles(50, 100);
    fm_sel_i <= 1'b0;
    code_i   <= 13'd3;
    run_cycles(40, 100);
    code_i   <= 13'd9;
    run_periods(3, 100);

    // R2: largest low-band code, 65536 input pulses
    cur_req = "R2";
    code_i <= 13'd8191;
    run_periods(2, 100);

    // R9: reset during a division, then restart per R1
    cur_req = "R9";
    code_i <= 13'd3;
    run_cycles(100, 100);
    @(negedge clk_i);
    rst_ni <= 1'b0;
    run_cycles(3, 100);
    @(negedge clk_i);
    rst_ni <= 1'b1;
    cur_req = "R1";
    run_periods(3, 100);

    finish_run();
  end
endmodule